// File: doc/BRIEF.md
# Asynchronous DRAM Pattern Tester

This block tests an older one-bit-wide asynchronous DRAM of 2^ADDR_W rows by 2^ADDR_W columns. The default is 512 x 512, which gives 262,144 cells. After a start pulse it runs four passes over the whole array:

1. It writes a checkerboard.
2. It reads the checkerboard back and compares each cell.
3. It writes the inverted checkerboard.
4. It reads the inverted checkerboard back and compares each cell.

Because of this, every cell is seen holding both a 0 and a 1. Any cell that returns a value other than the one written counts as damaged or upset. The block keeps a saturating error count and latches the row and column of the first mismatch. It raises done when the last read finishes.

The block drives row and column over one shared address bus. The row is strobed in with a falling row strobe and the column with a falling column strobe. Parameters set each strobe phase length in system clocks.

While a run is in progress, a refresh timer interleaves row-strobe-only refresh cycles between test accesses. These cycles step through all rows in turn.

Top module: `dram_tester`

## Requirements
- R1: After reset, both strobes and write-enable are high, the data driver is off, done is low and the error count is zero.
- R2: The column strobe is low only while the row strobe is low. While the row strobe is low and the column strobe is high, the address bus holds the row address. While the column strobe is low, the address bus holds the column address.
- R3: Phase lengths are never shorter than their parameters:
  - row strobe high (precharge): T_RP clocks;
  - row strobe fall to column strobe fall: T_RCD clocks;
  - column strobe low: T_CAS clocks;
  - row strobe low: T_RAS clocks.
- R4: In a write access, write-enable is already low in the clock before the column strobe falls and stays low while the column strobe is low. The data driver is on.
- R5: In a read access, write-enable stays high and the data driver is off. The data input is sampled on the T_SAMP-th rising clock edge after the column strobe falls.
- R6: Accesses run in four passes of 2^(2*ADDR_W) cells each, in this order:
  - write pass with polarity 0;
  - read pass with polarity 0;
  - write pass with polarity 1;
  - read pass with polarity 1.

  Within a pass the column counts up fastest, then the row. The bit written to cell (r,c) is polarity XOR r[0] XOR c[0].
- R7: Row-strobe-only refresh cycles, with no column strobe, address rows 0, 1, 2, ... and wrap around. While busy, consecutive refresh cycles are at most REF_GAP + 2*(T_RP+T_RCD+T_CAS+T_RAS) clocks apart.
- R8: Each read mismatch adds one to the error count. The count saturates at 2^ERR_W-1 and never decreases during a run.
- R9: The failing row and column outputs hold the address of the first mismatch of the run, in access order. They read zero while no mismatch has occurred.
- R10: Done rises after the final read access and holds. A start pulse while idle clears done, the error count and the failing address, and begins a run. A start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write-enable, active low |
| addr_o | output | ADDR_W | Multiplexed row/column address |
| dq_o | output | 1 | Write data bit |
| dq_oe_o | output | 1 | Data driver enable |
| dq_i | input | 1 | Read data bit from the DRAM |
| done_o | output | 1 | Test complete |
| err_cnt_o | output | ERR_W | Saturating mismatch count |
| fail_row_o | output | ADDR_W | Row of first mismatch |
| fail_col_o | output | ADDR_W | Column of first mismatch |

## Verification
The assertions assume the following about the inputs:
- Start arrives as a synchronous pulse that is low during reset.
- The DRAM output is only meaningful inside the sampling window of a read access.

The bench honours both assumptions:
- Start is driven on falling clock edges.
- The memory model returns the inverted bit until T_SAMP clocks after the column strobe falls. A read that samples early therefore produces a false mismatch, which the bench catches.

Fault injection uses stuck cells and a stuck-low data line. Each fault is placed so that its mismatches land in a chosen pass.

// File: rtl/dram_tester_pkg.sv
package dram_tester_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ROW,
    ST_COL
  } strobe_st_e;

  // checkerboard that flips with pass polarity
  function automatic logic cell_pattern(input logic pol, input logic r0, input logic c0);
    return pol ^ r0 ^ c0;
  endfunction

endpackage

// File: rtl/dram_walk.sv
module dram_walk import dram_tester_pkg::*; #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic              write_o,
  output logic              pattern_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

  logic [ADDR_W-1:0] row_q, col_q;
  logic              read_q, pol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      read_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (clear_i) begin
      row_q  <= '0;
      col_q  <= '0;
      read_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (step_i) begin
      col_q <= col_q + 1'b1;
      if (col_q == ADDR_MAX) begin
        row_q <= row_q + 1'b1;
        if (row_q == ADDR_MAX) begin
          read_q <= !read_q;
          if (read_q) pol_q <= !pol_q;
        end
      end
    end
  end

  assign row_o     = row_q;
  assign col_o     = col_q;
  assign write_o   = !read_q;
  assign pattern_o = cell_pattern(pol_q, row_q[0], col_q[0]);
  assign last_o    = pol_q && read_q && (row_q == ADDR_MAX) && (col_q == ADDR_MAX);

endmodule

// File: rtl/dram_refresh.sv
module dram_refresh #(
  parameter int ADDR_W  = 9,
  parameter int REF_GAP = 1500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              taken_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] row_o
);

  localparam int GAP_W = $clog2(REF_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(REF_GAP - 1);

  logic [GAP_W-1:0]  tmr_q;
  logic              pend_q;
  logic [ADDR_W-1:0] row_q;
  logic              hit;

  assign hit = busy_i && (tmr_q == GAP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      if (busy_i) tmr_q <= hit ? '0 : tmr_q + 1'b1;
      pend_q <= hit || (pend_q && !taken_i);
      if (taken_i) row_q <= row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

endmodule

// File: rtl/dram_strobe.sv
module dram_strobe import dram_tester_pkg::*; #(
  parameter int ADDR_W = 9,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAS  = 5,
  parameter int T_SAMP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic [ADDR_W-1:0] ref_row_i,
  input  logic              ref_pend_i,
  input  logic              write_i,
  input  logic              pattern_i,
  input  logic              last_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dq_o,
  output logic              dq_oe_o,
  output logic              idle_o,
  output logic              acc_done_o,
  output logic              ref_taken_o,
  output logic              sample_o
);

  localparam int T_M1  = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int T_M2  = (T_CAS > T_RAS) ? T_CAS : T_RAS;
  localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(T_MAX);

  strobe_st_e       st_q;
  logic [CNT_W-1:0] cnt_q, ras_cnt_q;
  logic             ref_q;
  logic             pre_end, row_end, col_end, ras_low;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_CAP) ? v : v + 1'b1;
  endfunction

  assign pre_end = (st_q == ST_PRE) && (cnt_q >= CNT_W'(T_RP - 1));
  assign row_end = (st_q == ST_ROW) &&
                   (ref_q ? (ras_cnt_q >= CNT_W'(T_RAS - 1)) : (cnt_q >= CNT_W'(T_RCD - 1)));
  assign col_end = (st_q == ST_COL) && (cnt_q >= CNT_W'(T_CAS - 1)) &&
                   (ras_cnt_q >= CNT_W'(T_RAS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      ras_cnt_q <= '0;
      ref_q     <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) st_q <= ST_PRE;
        end
        ST_PRE: begin
          if (pre_end) begin
            st_q      <= ST_ROW;
            cnt_q     <= '0;
            ras_cnt_q <= '0;
            ref_q     <= ref_pend_i;
          end else begin
            cnt_q <= sat_inc(cnt_q);
          end
        end
        ST_ROW: begin
          ras_cnt_q <= sat_inc(ras_cnt_q);
          if (row_end) begin
            st_q  <= ref_q ? ST_PRE : ST_COL;
            cnt_q <= '0;
          end else begin
            cnt_q <= sat_inc(cnt_q);
          end
        end
        ST_COL: begin
          ras_cnt_q <= sat_inc(ras_cnt_q);
          if (col_end) begin
            st_q  <= last_i ? ST_IDLE : ST_PRE;
            cnt_q <= '0;
          end else begin
            cnt_q <= sat_inc(cnt_q);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ras_low     = (st_q == ST_ROW) || (st_q == ST_COL);
  assign ras_n_o     = !ras_low;
  assign cas_n_o     = (st_q != ST_COL);
  assign we_n_o      = !(ras_low && !ref_q && write_i);
  assign dq_oe_o     = !we_n_o;
  assign dq_o        = dq_oe_o && pattern_i;
  assign addr_o      = (st_q == ST_COL) ? col_i : (ref_q && st_q == ST_ROW) ? ref_row_i : row_i;
  assign idle_o      = (st_q == ST_IDLE);
  assign acc_done_o  = col_end;
  assign ref_taken_o = row_end && ref_q;
  assign sample_o    = (st_q == ST_COL) && !write_i && (cnt_q == CNT_W'(T_SAMP - 1));

endmodule

// File: rtl/dram_score.sv
module dram_score #(
  parameter int ADDR_W = 9,
  parameter int ERR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              dq_i,
  input  logic              exp_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic [ADDR_W-1:0] fail_row_o,
  output logic [ADDR_W-1:0] fail_col_o
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [ERR_W-1:0]  err_q;
  logic [ADDR_W-1:0] frow_q, fcol_q;
  logic              miss;

  assign miss = sample_i && (dq_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= '0;
      frow_q <= '0;
      fcol_q <= '0;
    end else if (clear_i) begin
      err_q  <= '0;
      frow_q <= '0;
      fcol_q <= '0;
    end else if (miss) begin
      if (err_q != ERR_MAX) err_q <= err_q + 1'b1;
      if (err_q == '0) begin
        frow_q <= row_i;
        fcol_q <= col_i;
      end
    end
  end

  assign err_cnt_o  = err_q;
  assign fail_row_o = frow_q;
  assign fail_col_o = fcol_q;

endmodule

// File: rtl/dram_tester.sv
module dram_tester import dram_tester_pkg::*; #(
  parameter int ADDR_W  = 9,
  parameter int ERR_W   = 16,
  parameter int T_RP    = 3,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_RAS   = 5,
  parameter int T_SAMP  = 2,
  parameter int REF_GAP = 1500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dq_o,
  output logic              dq_oe_o,
  input  logic              dq_i,
  output logic              done_o,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic [ADDR_W-1:0] fail_row_o,
  output logic [ADDR_W-1:0] fail_col_o
);

  logic [ADDR_W-1:0] row, col, ref_row;
  logic write, pattern, last, ref_pend;
  logic idle, acc_done, ref_taken, sample, clear;
  logic done_q;

  assign clear = start_i && idle;

  dram_walk #(.ADDR_W(ADDR_W)) u_walk (
    .clk_i, .rst_ni,
    .clear_i   (clear),
    .step_i    (acc_done),
    .row_o     (row),
    .col_o     (col),
    .write_o   (write),
    .pattern_o (pattern),
    .last_o    (last)
  );

  dram_refresh #(.ADDR_W(ADDR_W), .REF_GAP(REF_GAP)) u_refresh (
    .clk_i, .rst_ni,
    .busy_i  (!idle),
    .taken_i (ref_taken),
    .pend_o  (ref_pend),
    .row_o   (ref_row)
  );

  dram_strobe #(
    .ADDR_W(ADDR_W), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_RAS(T_RAS), .T_SAMP(T_SAMP)
  ) u_strobe (
    .clk_i, .rst_ni, .start_i,
    .row_i       (row),
    .col_i       (col),
    .ref_row_i   (ref_row),
    .ref_pend_i  (ref_pend),
    .write_i     (write),
    .pattern_i   (pattern),
    .last_i      (last),
    .ras_n_o, .cas_n_o, .we_n_o, .addr_o, .dq_o, .dq_oe_o,
    .idle_o      (idle),
    .acc_done_o  (acc_done),
    .ref_taken_o (ref_taken),
    .sample_o    (sample)
  );

  dram_score #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_score (
    .clk_i, .rst_ni,
    .clear_i    (clear),
    .sample_i   (sample),
    .dq_i,
    .exp_i      (pattern),
    .row_i      (row),
    .col_i      (col),
    .err_cnt_o, .fail_row_o, .fail_col_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                done_q <= 1'b0;
    else if (clear)             done_q <= 1'b0;
    else if (acc_done && last)  done_q <= 1'b1;
  end

  assign done_o = done_q;

endmodule

// File: rtl/dram_tester_chk.sv
module dram_tester_chk #(
  parameter int ADDR_W = 9,
  parameter int ERR_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic [ERR_W-1:0]  err_cnt_o
);

  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  // R2
  cas_in_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> !ras_n_o);

  // R2
  col_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && $past(!cas_n_o)) |-> $stable(addr_o));

  // R4
  we_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && !we_n_o) |-> $past(!we_n_o));

  // R4
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cas_n_o && $past(!cas_n_o)) |-> $stable(we_n_o));

  // R8
  err_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) |-> (err_cnt_o >= $past(err_cnt_o)));

  // R8
  err_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == ERR_MAX && !start_i) |=> (err_cnt_o == ERR_MAX));

  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ras_n_o && cas_n_o && we_n_o));

endmodule

bind dram_tester dram_tester_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o), .done_o(done_o),
  .err_cnt_o(err_cnt_o)
);

// File: tb/tb_dram_tester.sv
module tb_dram_tester;

  localparam int CLK_P   = 10;
  localparam int AW      = 3;
  localparam int ROWS    = 1 << AW;
  localparam int NCELL   = ROWS * ROWS;
  localparam int EW      = 4;
  localparam int EMAX    = (1 << EW) - 1;
  localparam int T_RP    = 2;
  localparam int T_RCD   = 2;
  localparam int T_CAS   = 3;
  localparam int T_RAS   = 6;
  localparam int T_SAMP  = 2;
  localparam int REF_GAP = 40;
  localparam int BOUND   = REF_GAP + 2 * (T_RP + T_RCD + T_CAS + T_RAS);
  localparam int RUN_MAX = 20000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic ras_n, cas_n, we_n, dq_o, dq_oe, dq_i, done;
  logic [AW-1:0] addr, frow, fcol;
  logic [EW-1:0] err_cnt;

  int n_chk = 0, n_err = 0;
  int fault = 0;  // 0 none, 1 two stuck cells, 2 data line stuck low

  always #(CLK_P / 2) clk = !clk;

  dram_tester #(
    .ADDR_W(AW), .ERR_W(EW), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAS(T_RAS), .T_SAMP(T_SAMP), .REF_GAP(REF_GAP)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .dq_i(dq_i), .done_o(done),
    .err_cnt_o(err_cnt), .fail_row_o(frow), .fail_col_o(fcol)
  );

  // DRAM model and protocol monitor
  logic [NCELL-1:0] mem = '0;
  int row_lat = 0, col_lat = 0, cc = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1, got_cas = 0, ref_seen = 0;
  int hi_len = 1000, lo_len = 0, rcd = 0, cas_len = 0;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0;
  int n_acc = 0, n_ref = 0, ras_falls = 0, exp_ref = 0, cyc = 0, last_ref = 0;

  always @(posedge clk) cc <= cas_n ? 0 : cc + 1;

  always_comb begin
    logic v;
    v = mem[row_lat * ROWS + col_lat];
    if (fault == 1 && row_lat == 2 && col_lat == 3) v = 1'b1;
    if (fault == 1 && row_lat == 5 && col_lat == 4) v = 1'b0;
    if (fault == 2) v = 1'b0;
    if (!cas_n && we_n) dq_i = (cc >= T_SAMP - 1) ? v : !v;
    else dq_i = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_we = 1; hi_len = 1000; exp_ref = 0; got_cas = 0;
    end else begin
      if (!ras_n && p_ras) begin
        if (hi_len < T_RP) v_r3++;
        row_lat = int'(addr); lo_len = 1; rcd = 1; got_cas = 0; ras_falls++;
      end else if (!ras_n) begin
        lo_len++;
        if (cas_n && !got_cas) begin
          rcd++;
          if (int'(addr) != row_lat) v_r2++;
        end
      end
      if (ras_n && !p_ras) begin
        if (lo_len < T_RAS) v_r3++;
        if (!got_cas) begin
          n_ref++;
          if (row_lat != exp_ref) v_r7++;
          exp_ref = (exp_ref + 1) % ROWS;
          if (ref_seen && (cyc - last_ref) > BOUND) v_r7++;
          ref_seen = 1; last_ref = cyc;
        end
        hi_len = 1;
      end else if (ras_n) hi_len++;
      if (!cas_n && p_cas) begin
        int idx, pass, er, ec;
        if (ras_n) v_r2++;
        if (rcd < T_RCD) v_r3++;
        got_cas = 1; col_lat = int'(addr); cas_len = 1;
        idx = n_acc % NCELL; pass = n_acc / NCELL; er = idx / ROWS; ec = idx % ROWS;
        if (row_lat != er || col_lat != ec || pass > 3) v_r6++;
        if (!we_n) begin
          if (p_we) v_r4++;
          if (!dq_oe) v_r4++;
          if (pass % 2 != 0) v_r6++;
          if (dq_o != logic'(((pass / 2) ^ er ^ ec) & 1)) v_r6++;
          mem[row_lat * ROWS + col_lat] = dq_o;
        end else begin
          if (dq_oe) v_r5++;
          if (pass % 2 == 0) v_r6++;
        end
        n_acc++;
      end else if (!cas_n) begin
        cas_len++;
        if (int'(addr) != col_lat) v_r2++;
        if (we_n != p_we) v_r4++;
      end
      if (cas_n && !p_cas && cas_len < T_CAS) v_r3++;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1;
    v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r6 = 0; v_r7 = 0;
    n_acc = 0; n_ref = 0; ras_falls = 0; ref_seen = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < RUN_MAX; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    chk(ok, "R10", "done within watchdog", int'(done), 1);
  endtask

  task automatic run_test(input int f);
    bit ok;
    fault = f;
    clear_mon();
    pulse_start();
    wait_done(ok);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1", "strobes idle high", {ras_n, cas_n, we_n}, 7);
    chk(!dq_oe, "R1", "driver off", int'(dq_oe), 0);
    chk(!done, "R1", "done low", int'(done), 0);
    chk(err_cnt == 0, "R1", "err count", int'(err_cnt), 0);
  endtask

  task automatic t_clean();
    int falls;
    run_test(0);
    chk(v_r2 == 0, "R2", "address muxing violations", v_r2, 0);
    chk(v_r3 == 0, "R3", "phase length violations", v_r3, 0);
    chk(v_r4 == 0, "R4", "write cycle violations", v_r4, 0);
    chk(v_r5 == 0, "R5", "read cycle violations", v_r5, 0);
    chk(err_cnt == 0, "R5", "no false mismatch from sample point", int'(err_cnt), 0);
    chk(v_r6 == 0, "R6", "order/pattern violations", v_r6, 0);
    chk(n_acc == 4 * NCELL, "R6", "access count", n_acc, 4 * NCELL);
    chk(v_r7 == 0, "R7", "refresh row/gap violations", v_r7, 0);
    chk(n_ref > 0, "R7", "refresh cycles seen", n_ref, 1);
    chk(frow == 0 && fcol == 0, "R9", "fail address without mismatch", {frow, fcol}, 0);
    falls = ras_falls;
    repeat (30) @(negedge clk);
    chk(done, "R10", "done holds", int'(done), 1);
    chk(ras_falls == falls, "R10", "no activity after done", ras_falls - falls, 0);
  endtask

  task automatic t_stuck_cells();
    run_test(1);
    chk(err_cnt == 2, "R8", "two stuck cells", int'(err_cnt), 2);
    chk(frow == 5, "R9", "first fail row", int'(frow), 5);
    chk(fcol == 4, "R9", "first fail col", int'(fcol), 4);
  endtask

  task automatic t_stuck_low();
    int ones = 0, exp;
    run_test(2);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < ROWS; c++)
          if (((p ^ r ^ c) & 1) == 1) ones++;
    exp = (ones > EMAX) ? EMAX : ones;
    chk(int'(err_cnt) == exp, "R8", "saturated count", int'(err_cnt), exp);
    chk(frow == 0 && fcol == 1, "R9", "first fail of stuck-low line", {frow, fcol}, 1);
  endtask

  task automatic t_restart();
    bit ok;
    fault = 0;
    clear_mon();
    pulse_start();
    @(negedge clk);
    chk(!done, "R10", "start clears done", int'(done), 0);
    chk(err_cnt == 0, "R10", "start clears err count", int'(err_cnt), 0);
    chk(frow == 0 && fcol == 0, "R10", "start clears fail address", {frow, fcol}, 0);
    repeat (200) @(negedge clk);
    pulse_start();
    wait_done(ok);
    chk(n_acc == 4 * NCELL, "R10", "start during run ignored", n_acc, 4 * NCELL);
    chk(err_cnt == 0, "R10", "clean rerun", int'(err_cnt), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean();
    t_stuck_cells();
    t_stuck_low();
    t_restart();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule